// File: doc/BRIEF.md
# Protected Register Write Lock with Channel Polarity

This block decides whether protected configuration fields may be changed. It keeps one protection state. Software sees that state in two places: an enable bit in a status register and a disable bit in a mode register. The disable bit always reads as the inverse of the enable bit. Turning protection on takes a single write. Turning it off takes two steps: first read the status register while protection is on, which arms an unlock, and then write 1 to the disable bit in the mode register.

The protected field in this block is a per-channel polarity register. Each polarity bit either passes its channel input straight to the output or inverts it. The polarity register can be written only while protection is off.

The register port is synchronous, with address, write data, write strobe, read strobe and combinational read data. Of the read accesses, only a read of the status register has a side effect, and that read is what arms the unlock.

Top module: `wpl_guard_bank`

## Requirements
- R1: After reset, the status register (address 0) reads all zeros, the mode register (address 1) reads 1 in bit 0, the polarity register (address 2) reads 0, and every channel output equals its input.
- R2: Mode bit 0 (protection disable) always reads as the inverse of status bit 0 (protection enable).
- R3: A write to the status register with bit 0 set turns protection on. A status write with bit 0 clear leaves the protection state unchanged.
- R4: A status read (read strobe at address 0) while protection is on arms an unlock. The next mode write with bit 0 set then turns protection off.
- R5: Any mode write consumes the armed flag, whatever its data. A mode write with bit 0 clear, a mode write without a prior arming read, or a second mode write after the arm was consumed all leave protection on.
- R6: A status read while protection is off does not arm. If protection is turned on afterwards, a mode write with bit 0 set leaves it on.
- R7: A write to the polarity register loads its low NCH bits only while protection is off. While protection is on, the write is ignored and the register keeps its value.
- R8: Channel output n equals channel input n XOR polarity bit n. A polarity bit of 0 makes the channel active high and a 1 makes it active low.
- R9: Register bits above the defined fields, and every address other than 0, 1 and 2, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (arms an unlock when used at the status address) |
| rdata | output | DW | Read data for the register at addr |
| ch_in | input | NCH | Raw channel signals |
| ch_out | output | NCH | Channel signals after polarity |

## Verification
The bench builds the block with NCH = 6 and DW = 8. With these values bits 6 and 7 of the polarity register are unused, so the bench can show that written ones in those bits never read back. The 4-bit address gives thirteen unmapped addresses that random reads and writes can hit. Directed sequences cover the arm-then-unlock order, a consumed arm, an arm attempted while protection is off, and a polarity write while protection is on. A seeded random mix of accesses to all addresses follows, with each result compared against a bench model of the lock.

// File: rtl/wpl_pkg.sv
package wpl_pkg;
  // bit positions of the two views of the protection state
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned DIS_BIT = 0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MODE = 2'd2,
    SEL_POL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wpl_lock_ctrl.sv
module wpl_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic mode_wr,
  input  logic set_bit,
  input  logic clr_bit,
  output logic prot_on,
  output logic armed
);
  logic lock_evt;
  logic unlock_evt;
  logic arm_evt;

  assign lock_evt   = stat_wr & set_bit;
  assign unlock_evt = mode_wr & armed & clr_bit;
  assign arm_evt    = stat_rd & prot_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_on <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (lock_evt)        prot_on <= 1'b1;
      else if (unlock_evt) prot_on <= 1'b0;
      if (mode_wr)         armed <= 1'b0;
      else if (arm_evt)    armed <= 1'b1;
    end
  end

  // R3: a set write locks on the next cycle
  p_lock_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && set_bit) |=> prot_on);
  // R4: an armed mode write with the disable bit set unlocks
  p_unlock_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && armed && clr_bit) |=> !prot_on);
  // R5: a mode write without an arm never changes the state
  p_no_unarmed_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !armed) |=> $stable(prot_on));
  // R5: every mode write consumes the arm
  p_arm_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !armed);
  // R6: a status read while unlocked does not arm
  p_no_arm_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !prot_on && !armed) |=> !armed);
endmodule

// File: rtl/wpl_polarity.sv
module wpl_polarity #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pol_wr,
  input  logic           locked,
  input  logic [NCH-1:0] pol_wdata,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] pol_q,
  output logic [NCH-1:0] ch_out
);
  logic pol_load;

  function automatic logic [NCH-1:0] apply_pol(input logic [NCH-1:0] raw,
                                               input logic [NCH-1:0] pol);
    return raw ^ pol;
  endfunction

  assign pol_load = pol_wr & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pol_q <= '0;
    else if (pol_load) pol_q <= pol_wdata;
  end

  assign ch_out = apply_pol(ch_in, pol_q);

  // R7: the polarity register cannot change while protection is on
  p_pol_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(pol_q));
  // R7: an unprotected write lands in the register
  p_pol_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_wr && !locked) |=> (pol_q == $past(pol_wdata)));
endmodule

// File: rtl/wpl_regmap.sv
module wpl_regmap
  import wpl_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned NCH       = 8,
  parameter int unsigned ADDR_STAT = 0,
  parameter int unsigned ADDR_MODE = 1,
  parameter int unsigned ADDR_POL  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic           prot_on,
  input  logic [NCH-1:0] pol_q,
  output logic           stat_rd,
  output logic           stat_wr,
  output logic           mode_wr,
  output logic           pol_wr,
  output logic [DW-1:0]  rdata
);
  reg_sel_e sel;
  logic [DW-1:0] stat_word;
  logic [DW-1:0] mode_word;
  logic [DW-1:0] pol_word;

  always_comb begin
    if (addr == AW'(ADDR_STAT))      sel = SEL_STAT;
    else if (addr == AW'(ADDR_MODE)) sel = SEL_MODE;
    else if (addr == AW'(ADDR_POL))  sel = SEL_POL;
    else                             sel = SEL_NONE;
  end

  assign stat_rd = rd_en & (sel == SEL_STAT);
  assign stat_wr = wr_en & (sel == SEL_STAT);
  assign mode_wr = wr_en & (sel == SEL_MODE);
  assign pol_wr  = wr_en & (sel == SEL_POL);

  always_comb begin
    stat_word          = '0;
    stat_word[EN_BIT]  = prot_on;
    mode_word          = '0;
    mode_word[DIS_BIT] = ~prot_on;
    pol_word           = '0;
    pol_word[NCH-1:0]  = pol_q;
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata = stat_word;
      SEL_MODE: rdata = mode_word;
      SEL_POL:  rdata = pol_word;
      default:  rdata = '0;
    endcase
  end

  // decoded strobes are mutually exclusive
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_wr, mode_wr, pol_wr}));
endmodule

// File: rtl/wpl_guard_bank.sv
module wpl_guard_bank
  import wpl_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned NCH       = 8,
  parameter int unsigned ADDR_STAT = 0,
  parameter int unsigned ADDR_MODE = 1,
  parameter int unsigned ADDR_POL  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic           wr_en,
  input  logic           rd_en,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] ch_out
);
  logic           stat_rd, stat_wr, mode_wr, pol_wr;
  logic           prot_on, armed;
  logic [NCH-1:0] pol_q;

  wpl_regmap #(
    .AW(AW), .DW(DW), .NCH(NCH),
    .ADDR_STAT(ADDR_STAT), .ADDR_MODE(ADDR_MODE), .ADDR_POL(ADDR_POL)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .prot_on(prot_on), .pol_q(pol_q),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .mode_wr(mode_wr), .pol_wr(pol_wr),
    .rdata(rdata)
  );

  wpl_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .mode_wr(mode_wr),
    .set_bit(wdata[EN_BIT]), .clr_bit(wdata[DIS_BIT]),
    .prot_on(prot_on), .armed(armed)
  );

  wpl_polarity #(.NCH(NCH)) u_pol (
    .clk(clk), .rst_n(rst_n), .pol_wr(pol_wr), .locked(prot_on),
    .pol_wdata(wdata[NCH-1:0]), .ch_in(ch_in),
    .pol_q(pol_q), .ch_out(ch_out)
  );

  // R2: the two views stay complementary (checked as state vs. mode readback)
  p_views_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(ADDR_MODE)) |-> (rdata[DIS_BIT] == !prot_on));
endmodule

// File: tb/wpl_guard_bank_test.sv
module wpl_guard_bank_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] ch_in = '0;
  logic [NCH-1:0] ch_out;

  int checks = 0, errors = 0, cycles = 0;
  bit m_lock = 0, m_armed = 0;
  logic [NCH-1:0] m_pol = '0;

  wpl_guard_bank #(.AW(AW), .DW(DW), .NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .ch_in(ch_in), .ch_out(ch_out)
  );

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] exp_word(input int a);
    logic [DW-1:0] w = '0;
    if (a == 0) w[0] = m_lock;
    else if (a == 1) w[0] = !m_lock;
    else if (a == 2) w[NCH-1:0] = m_pol;
    return w;
  endfunction

  function automatic logic [NCH-1:0] exp_out(input logic [NCH-1:0] raw);
    logic [NCH-1:0] o;
    for (int i = 0; i < NCH; i++) o[i] = m_pol[i] ? !raw[i] : raw[i];
    return o;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input string req, input int a);
    @(negedge clk);
    addr = AW'(a); wr_en = 0; rd_en = 0;
    #2 check(req, rdata, exp_word(a));
  endtask

  task automatic chk_out(input string req);
    @(negedge clk);
    ch_in = NCH'($urandom);
    #2 check(req, DW'(ch_out), DW'(exp_out(ch_in)));
  endtask

  task automatic op(input int a, input logic [DW-1:0] d, input bit w, input bit r);
    bit old_lock;
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = w; rd_en = r;
    @(posedge clk);
    #1;
    old_lock = m_lock;
    if (w && a == 0 && d[0]) m_lock = 1;
    if (w && a == 1) begin
      if (m_armed && d[0]) m_lock = 0;
      m_armed = 0;
    end else if (r && a == 0 && old_lock) m_armed = 1;
    if (w && a == 2 && !old_lock) m_pol = d[NCH-1:0];
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek("R1 status", 0); peek("R1 mode", 1); peek("R1 pol", 2); chk_out("R1 out");
    // R9 unmapped
    peek("R9 addr3", 3); peek("R9 addr15", 15);
    // R7 unlocked write, R9 upper bits
    op(2, 8'hEA, 1, 0); peek("R7 pol load", 2); chk_out("R8 out");
    // R3 write 0 no effect, write 1 locks, R2 views
    op(0, 8'hFE, 1, 0); peek("R3 zero write", 1);
    op(0, 8'h01, 1, 0); peek("R3 locked", 0); peek("R2 mode view", 1);
    // R7 locked write ignored
    op(2, 8'h15, 1, 0); peek("R7 ignored", 2); chk_out("R8 out locked");
    // R5 unarmed unlock attempt
    op(1, 8'h01, 1, 0); peek("R5 unarmed", 0);
    // R5 arm, write 0, then 1: arm consumed
    op(0, 0, 0, 1); op(1, 8'h00, 1, 0); peek("R5 zero data", 0);
    op(1, 8'h01, 1, 0); peek("R5 consumed", 0);
    // R4 proper sequence
    op(0, 0, 0, 1); op(1, 8'h01, 1, 0); peek("R4 unlock", 0); peek("R2 after unlock", 1);
    // R6 read while unlocked does not arm
    op(0, 0, 0, 1); op(0, 8'h01, 1, 0); op(1, 8'h01, 1, 0); peek("R6 no arm", 0);
    op(0, 0, 0, 1); op(1, 8'h01, 1, 0); peek("R4 unlock again", 0);
    op(2, 8'h3F, 1, 0); chk_out("R8 all low");
    // random mix
    for (int i = 0; i < 500; i++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 3);
      op(a, DW'($urandom), 1'($urandom), 1'($urandom));
      peek("R2 random mode", 1);
      peek("R7 random pol", 2);
      peek("R9 random any", int'($urandom % 16));
      chk_out("R8 random out");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule